// File: doc/BRIEF.md
# DRAM Reclocking Command Sequencer

This block moves an external DDR2, DDR3 or GDDR3 memory from one operating frequency to another without losing data. A single start pulse supplies a memory-type code and the target values of mode registers 0, 1 and 2. The sequencer first reads the current mode registers back. If the DLL is being switched off, it does that before anything else. It then parks the memory in self-refresh and asks for the clock change. After that it brings the memory out of self-refresh, rewrites only the mode registers whose value changes, and asks for the timing registers to be updated. When the target keeps the DLL enabled, it finishes with a DLL reset and a lock wait.

Every action leaves the block on one command port as a single-cycle strobe with an opcode, a mode-register index and a data word. The sequencer holds the port and waits for an acknowledge from the PHY or clock logic before it moves on. Delays are given in nanoseconds and counted in clock cycles by an internal timer. A one-cycle done pulse with an error flag ends every sequence.

Top module: `dram_reclk_seq`

## Requirements
- R1: After a synchronous active-low reset, busy, done, error and the command strobe are all low.
- R2: Opcodes are precharge=0, refresh=1, auto-refresh off=2, auto-refresh on=3, self-refresh on=4, self-refresh off=5, mode-register write=6, mode-register read=7, clock change=8 and timing update=9. The strobe lasts one cycle. Opcode, index and data hold until the acknowledge, which counts only in a cycle after the strobe. The next strobe comes no earlier than the cycle after the acknowledge is sampled. Commands other than mode-register read and write drive index and data to zero.
- R3: Type codes are 0 for DDR2, 1 for DDR3 and 2 for GDDR3. Code 3 raises done with the error flag in the cycle after start and issues no command.
- R4: Mode-register reads come first: MR2 (DDR3 only), then MR1, then MR0, with the read data taken on the acknowledge. For DDR2 and GDDR3, the current value of MR2 is taken to be its target value.
- R5: The DLL-off flag in MR1 is bit 0 for DDR2 and DDR3 and bit 6 for GDDR3. If the flag is clear in the current MR1 and set in the target MR1, the sequencer issues a precharge, then writes MR1 as the current value with the flag set, then waits tMRD (1000 ns). All of this happens before self-refresh entry.
- R6: The self-refresh and clock phase runs in this order: precharge, refresh, refresh, auto-refresh off, self-refresh on, wait tCKSRE, clock change, wait tCKSRX, precharge, self-refresh off, auto-refresh on, wait tXS. By default tCKSRE, tCKSRX and tXS are 0 ns.
- R7: Mode registers are then written in the order MR2, MR1, MR0, each with its target value. A write is skipped when the target equals the current value. Each write is followed by a tMRD wait.
- R8: A timing-update command follows. If the target MR1 has the DLL enabled, the sequencer writes MR0 as the target with bit 8 set, waits tMRD, writes MR0 as the target with bit 8 cleared, waits tMRD, and then waits the DLL lock time: 2000 ns for DDR2, 12000 ns for DDR3, 40000 ns for GDDR3.
- R9: For GDDR3 only, one precharge is issued after the DLL-reset waits. No such precharge is issued when the DLL reset is skipped.
- R10: A wait of N ns lasts ceil(N / clock period) cycles, and a 0 ns wait lasts exactly one cycle.
- R11: Busy rises in the cycle after an accepted start and stays high through the one-cycle done pulse. Done comes at the end of the last wait or in the cycle after the last acknowledge. The error flag is high only together with done.
- R12: A start while busy, including the done cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| mem_kind_i | input | 2 | Memory type code |
| tgt_mr0_i | input | MR_W | Target MR0 |
| tgt_mr1_i | input | MR_W | Target MR1 |
| tgt_mr2_i | input | MR_W | Target MR2 |
| cmd_stb_o | output | 1 | Single-cycle command strobe |
| cmd_op_o | output | 4 | Command opcode |
| cmd_mr_o | output | 2 | Mode-register index |
| cmd_data_o | output | MR_W | Mode-register write data |
| cmd_ack_i | input | 1 | Command acknowledge |
| rd_data_i | input | MR_W | Mode-register read data, valid with the acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | End-of-sequence pulse |
| err_o | output | 1 | Error status, valid with done |

## Verification
A new start request can arrive in the same cycle as the done pulse that ends the previous sequence. In that cycle the block is still busy, so the request must be refused, even though one cycle later it would be accepted. The bench predicts the exact done cycle from the command list and wait lengths it builds itself. In that cycle it raises start with a valid type, then checks that busy drops and no further strobe appears. It also sends an invalid-type start in the middle of a run and checks that the command log is unchanged.

// File: rtl/dram_reclk_pkg.sv
`timescale 1ns/1ps
// Shared opcode, memory-type and sequencer-state types of the reclocking sequencer.
package dram_reclk_pkg;

    typedef enum logic [3:0] {
        OP_PRECHG   = 4'd0,
        OP_REFRESH  = 4'd1,
        OP_AREF_OFF = 4'd2,
        OP_AREF_ON  = 4'd3,
        OP_SREF_ON  = 4'd4,
        OP_SREF_OFF = 4'd5,
        OP_MR_WRITE = 4'd6,
        OP_MR_READ  = 4'd7,
        OP_CLK_CHG  = 4'd8,
        OP_TIMING   = 4'd9
    } cmd_op_e;

    typedef enum logic [1:0] {
        MK_DDR2  = 2'd0,
        MK_DDR3  = 2'd1,
        MK_GDDR3 = 2'd2,
        MK_BAD   = 2'd3
    } mem_kind_e;

    typedef enum logic [5:0] {
        ST_IDLE, ST_RD2, ST_RD1, ST_RD0,
        ST_DOFF_PRE, ST_DOFF_MRS, ST_DOFF_W,
        ST_E_PRE, ST_E_REF1, ST_E_REF2, ST_E_AOFF, ST_E_SON, ST_E_W,
        ST_CLK, ST_X_W, ST_X_PRE, ST_X_SOFF, ST_X_AON, ST_X_W2,
        ST_M2, ST_M2W, ST_M1, ST_M1W, ST_M0, ST_M0W,
        ST_TIM, ST_R_SET, ST_R_SETW, ST_R_CLR, ST_R_CLRW, ST_R_LOCK,
        ST_G_PRE, ST_DONE
    } seq_state_e;

endpackage

// File: rtl/reclk_kind_decode.sv
`timescale 1ns/1ps
// Memory-type decode: maps the type code to its DLL-off mask, DLL lock time,
// whether MR2 is read back, and whether a trailing precharge follows the DLL reset.
// Assumes: code 3 is unsupported; purely combinational.
module reclk_kind_decode #(
    parameter int MR_W              = 16,
    parameter int NS_W              = 32,
    parameter int T_DLLK_DDR2_NS    = 2000,
    parameter int T_DLLK_DDR3_NS    = 12000,
    parameter int T_DLLK_GDDR3_NS   = 40000
) (
    input  logic [1:0]      kind_i,
    output logic            supported_o,
    output logic            reads_mr2_o,
    output logic            trail_pre_o,
    output logic [MR_W-1:0] dll_off_mask_o,
    output logic [NS_W-1:0] dllk_ns_o
);
    import dram_reclk_pkg::*;

    // Per-type constants selected by the code.
    always_comb begin
        supported_o    = 1'b1;
        reads_mr2_o    = 1'b0;
        trail_pre_o    = 1'b0;
        dll_off_mask_o = MR_W'(1);
        dllk_ns_o      = NS_W'(T_DLLK_DDR2_NS);
        case (mem_kind_e'(kind_i))
            MK_DDR2: ;
            MK_DDR3: begin
                reads_mr2_o = 1'b1;
                dllk_ns_o   = NS_W'(T_DLLK_DDR3_NS);
            end
            MK_GDDR3: begin
                trail_pre_o    = 1'b1;
                dll_off_mask_o = MR_W'(64);
                dllk_ns_o      = NS_W'(T_DLLK_GDDR3_NS);
            end
            default: supported_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/reclk_wait_timer.sv
`timescale 1ns/1ps
// Wait timer: converts a nanosecond delay into clock cycles (rounded up,
// minimum one) and flags the last cycle of the wait.
// Assumes: load_i is high in the first cycle of a wait only; expired_o is
// combinational and marks the final cycle.
module reclk_wait_timer #(
    parameter int CLK_NS = 5,
    parameter int NS_W   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [NS_W-1:0] ns_i,
    output logic            expired_o
);
    localparam logic [NS_W-1:0] ONE     = NS_W'(1);
    localparam logic [NS_W-1:0] PERIOD  = NS_W'(CLK_NS);
    localparam logic [NS_W-1:0] ROUNDUP = NS_W'(CLK_NS - 1);

    logic [NS_W-1:0] need;
    logic [NS_W-1:0] cnt;

    // Cycle count for the requested delay, at least one.
    always_comb begin
        need = (ns_i == '0) ? ONE : (ns_i + ROUNDUP) / PERIOD;
    end

    // Last cycle: either a one-cycle wait just loaded, or the countdown reaching one.
    always_comb begin
        expired_o = load_i ? (need == ONE) : (cnt == ONE);
    end

    // Countdown of the remaining cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load_i)      cnt <= need - ONE;
        else if (cnt != '0)   cnt <= cnt - ONE;
    end
endmodule

// File: rtl/dram_reclk_seq.sv
`timescale 1ns/1ps
// Reclocking command sequencer: reads the current mode registers, optionally
// disables the DLL, brackets a clock change with self-refresh, rewrites changed
// mode registers, requests a timing update and optionally resets the DLL.
// Assumes: one command outstanding at a time; an acknowledge counts only after
// the strobe cycle; read data is valid together with its acknowledge.
module dram_reclk_seq #(
    parameter int MR_W             = 16,
    parameter int NS_W             = 32,
    parameter int CLK_NS           = 5,
    parameter int T_MRD_NS         = 1000,
    parameter int T_CKSRE_NS       = 0,
    parameter int T_CKSRX_NS       = 0,
    parameter int T_XS_NS          = 0,
    parameter int T_DLLK_DDR2_NS   = 2000,
    parameter int T_DLLK_DDR3_NS   = 12000,
    parameter int T_DLLK_GDDR3_NS  = 40000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      mem_kind_i,
    input  logic [MR_W-1:0] tgt_mr0_i,
    input  logic [MR_W-1:0] tgt_mr1_i,
    input  logic [MR_W-1:0] tgt_mr2_i,
    output logic            cmd_stb_o,
    output logic [3:0]      cmd_op_o,
    output logic [1:0]      cmd_mr_o,
    output logic [MR_W-1:0] cmd_data_o,
    input  logic            cmd_ack_i,
    input  logic [MR_W-1:0] rd_data_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            err_o
);
    import dram_reclk_pkg::*;

    localparam logic [MR_W-1:0] DLL_RST = MR_W'(256);

    seq_state_e      state, succ;
    logic            issued, fail_q;
    logic [1:0]      kind_q, kind_sel;
    logic [MR_W-1:0] tgt0, tgt1, tgt2, cur0, cur1, cur2;
    logic            is_cmd, is_wait, step, expired;
    cmd_op_e         op;
    logic [1:0]      mr_idx;
    logic [MR_W-1:0] data;
    logic [NS_W-1:0] wait_ns;
    logic            supported, reads_mr2, trail_pre;
    logic [MR_W-1:0] dll_mask;
    logic [NS_W-1:0] dllk_ns;
    logic            dll_off_now, tgt_dll_on, d0, d1, d2;
    seq_state_e      after_x, after_m2, after_m1, after_lock;

    // Decode the incoming code while idle, the latched code otherwise.
    assign kind_sel = (state == ST_IDLE) ? mem_kind_i : kind_q;

    reclk_kind_decode #(
        .MR_W(MR_W), .NS_W(NS_W),
        .T_DLLK_DDR2_NS(T_DLLK_DDR2_NS), .T_DLLK_DDR3_NS(T_DLLK_DDR3_NS),
        .T_DLLK_GDDR3_NS(T_DLLK_GDDR3_NS)
    ) i_decode (
        .kind_i(kind_sel), .supported_o(supported), .reads_mr2_o(reads_mr2),
        .trail_pre_o(trail_pre), .dll_off_mask_o(dll_mask), .dllk_ns_o(dllk_ns)
    );

    reclk_wait_timer #(.CLK_NS(CLK_NS), .NS_W(NS_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load_i(is_wait && !issued),
        .ns_i(wait_ns), .expired_o(expired)
    );

    // Comparisons of current against target register state.
    always_comb begin
        dll_off_now = ((cur1 & dll_mask) == '0) && ((tgt1 & dll_mask) != '0);
        tgt_dll_on  = ((tgt1 & dll_mask) == '0);
        d2 = (cur2 != tgt2);
        d1 = (cur1 != tgt1);
        d0 = (cur0 != tgt0);
        after_m1   = d0 ? ST_M0 : ST_TIM;
        after_m2   = d1 ? ST_M1 : after_m1;
        after_x    = d2 ? ST_M2 : after_m2;
        after_lock = trail_pre ? ST_G_PRE : ST_DONE;
    end

    // Per-state command fields, wait length and successor.
    always_comb begin
        is_cmd = 1'b0; is_wait = 1'b0; op = OP_PRECHG; mr_idx = 2'd0;
        data = '0; wait_ns = NS_W'(T_MRD_NS); succ = ST_IDLE;
        case (state)
            ST_RD2:      begin is_cmd = 1'b1; op = OP_MR_READ; mr_idx = 2'd2; succ = ST_RD1; end
            ST_RD1:      begin is_cmd = 1'b1; op = OP_MR_READ; mr_idx = 2'd1; succ = ST_RD0; end
            ST_RD0:      begin is_cmd = 1'b1; op = OP_MR_READ;
                               succ = dll_off_now ? ST_DOFF_PRE : ST_E_PRE; end
            ST_DOFF_PRE: begin is_cmd = 1'b1; succ = ST_DOFF_MRS; end
            ST_DOFF_MRS: begin is_cmd = 1'b1; op = OP_MR_WRITE; mr_idx = 2'd1;
                               data = cur1 | dll_mask; succ = ST_DOFF_W; end
            ST_DOFF_W:   begin is_wait = 1'b1; succ = ST_E_PRE; end
            ST_E_PRE:    begin is_cmd = 1'b1; succ = ST_E_REF1; end
            ST_E_REF1:   begin is_cmd = 1'b1; op = OP_REFRESH; succ = ST_E_REF2; end
            ST_E_REF2:   begin is_cmd = 1'b1; op = OP_REFRESH; succ = ST_E_AOFF; end
            ST_E_AOFF:   begin is_cmd = 1'b1; op = OP_AREF_OFF; succ = ST_E_SON; end
            ST_E_SON:    begin is_cmd = 1'b1; op = OP_SREF_ON; succ = ST_E_W; end
            ST_E_W:      begin is_wait = 1'b1; wait_ns = NS_W'(T_CKSRE_NS); succ = ST_CLK; end
            ST_CLK:      begin is_cmd = 1'b1; op = OP_CLK_CHG; succ = ST_X_W; end
            ST_X_W:      begin is_wait = 1'b1; wait_ns = NS_W'(T_CKSRX_NS); succ = ST_X_PRE; end
            ST_X_PRE:    begin is_cmd = 1'b1; succ = ST_X_SOFF; end
            ST_X_SOFF:   begin is_cmd = 1'b1; op = OP_SREF_OFF; succ = ST_X_AON; end
            ST_X_AON:    begin is_cmd = 1'b1; op = OP_AREF_ON; succ = ST_X_W2; end
            ST_X_W2:     begin is_wait = 1'b1; wait_ns = NS_W'(T_XS_NS); succ = after_x; end
            ST_M2:       begin is_cmd = 1'b1; op = OP_MR_WRITE; mr_idx = 2'd2; data = tgt2; succ = ST_M2W; end
            ST_M2W:      begin is_wait = 1'b1; succ = after_m2; end
            ST_M1:       begin is_cmd = 1'b1; op = OP_MR_WRITE; mr_idx = 2'd1; data = tgt1; succ = ST_M1W; end
            ST_M1W:      begin is_wait = 1'b1; succ = after_m1; end
            ST_M0:       begin is_cmd = 1'b1; op = OP_MR_WRITE; data = tgt0; succ = ST_M0W; end
            ST_M0W:      begin is_wait = 1'b1; succ = ST_TIM; end
            ST_TIM:      begin is_cmd = 1'b1; op = OP_TIMING;
                               succ = tgt_dll_on ? ST_R_SET : ST_DONE; end
            ST_R_SET:    begin is_cmd = 1'b1; op = OP_MR_WRITE; data = tgt0 | DLL_RST; succ = ST_R_SETW; end
            ST_R_SETW:   begin is_wait = 1'b1; succ = ST_R_CLR; end
            ST_R_CLR:    begin is_cmd = 1'b1; op = OP_MR_WRITE; data = tgt0 & ~DLL_RST; succ = ST_R_CLRW; end
            ST_R_CLRW:   begin is_wait = 1'b1; succ = ST_R_LOCK; end
            ST_R_LOCK:   begin is_wait = 1'b1; wait_ns = dllk_ns; succ = after_lock; end
            ST_G_PRE:    begin is_cmd = 1'b1; succ = ST_DONE; end
            default:     ;
        endcase
    end

    // A step ends on an acknowledge after the strobe, or on the timer's last cycle.
    assign step = (is_cmd && issued && cmd_ack_i) || (is_wait && expired);

    // Sequencer state, latched request and captured mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; issued <= 1'b0; fail_q <= 1'b0; kind_q <= 2'd0;
            tgt0 <= '0; tgt1 <= '0; tgt2 <= '0; cur0 <= '0; cur1 <= '0; cur2 <= '0;
        end else if (state == ST_IDLE) begin
            issued <= 1'b0;
            if (start_i) begin
                kind_q <= mem_kind_i;
                tgt0 <= tgt_mr0_i; tgt1 <= tgt_mr1_i; tgt2 <= tgt_mr2_i;
                cur2 <= tgt_mr2_i;
                fail_q <= !supported;
                state  <= !supported ? ST_DONE : (reads_mr2 ? ST_RD2 : ST_RD1);
            end
        end else if (state == ST_DONE) begin
            state <= ST_IDLE;
        end else begin
            if (step) begin
                state  <= succ;
                issued <= 1'b0;
            end else begin
                issued <= 1'b1;
            end
            if (is_cmd && issued && cmd_ack_i) begin
                if (state == ST_RD2) cur2 <= rd_data_i;
                if (state == ST_RD1) cur1 <= rd_data_i;
                if (state == ST_RD0) cur0 <= rd_data_i;
            end
        end
    end

    // Command port and status outputs.
    assign cmd_stb_o  = is_cmd && !issued;
    assign cmd_op_o   = op;
    assign cmd_mr_o   = mr_idx;
    assign cmd_data_o = data;
    assign busy_o     = (state != ST_IDLE);
    assign done_o     = (state == ST_DONE);
    assign err_o      = (state == ST_DONE) && fail_q;
endmodule

// File: rtl/dram_reclk_seq_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for the reclocking sequencer, bound to the top.
// Assumes: synchronous active-low reset; observes ports only.
module dram_reclk_seq_chk #(
    parameter int MR_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [1:0]      mem_kind_i,
    input logic            cmd_stb_o,
    input logic [3:0]      cmd_op_o,
    input logic [1:0]      cmd_mr_o,
    input logic [MR_W-1:0] cmd_data_o,
    input logic            cmd_ack_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            err_o
);
    logic pend;

    // Tracks a strobed command that has not yet been acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend <= 1'b0;
        else if (cmd_stb_o)  pend <= 1'b1;
        else if (cmd_ack_i)  pend <= 1'b0;
    end

    // R2
    no_stb_while_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> !cmd_stb_o);
    // R2
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> ($stable(cmd_op_o) && $stable(cmd_mr_o) && $stable(cmd_data_o)));
    // R2
    stb_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |-> busy_o);
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R11
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
    // R11
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);
    // R12
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    // R3
    bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && mem_kind_i == 2'd3) |=> (done_o && err_o));
endmodule

bind dram_reclk_seq dram_reclk_seq_chk #(.MR_W(MR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_kind_i(mem_kind_i),
    .cmd_stb_o(cmd_stb_o), .cmd_op_o(cmd_op_o), .cmd_mr_o(cmd_mr_o),
    .cmd_data_o(cmd_data_o), .cmd_ack_i(cmd_ack_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
);

// File: tb/test_dram_reclk_seq.sv
`timescale 1ns/1ps
// Directed bench: a responder acknowledges each strobe one cycle later and
// models the mode registers; each scenario task predicts the full command log
// with cycle stamps and the done cycle from the requirements.
module test_dram_reclk_seq;
    localparam int OPC_PRE = 0, OPC_REF = 1, OPC_AOFF = 2, OPC_AON = 3,
                   OPC_SON = 4, OPC_SOFF = 5, OPC_MRW = 6, OPC_MRR = 7,
                   OPC_CLK = 8, OPC_TIM = 9;
    localparam int W_MRD = 200;   // 1000 ns at 5 ns, R10
    localparam int W_ZERO = 1;    // 0 ns waits, R10

    logic        clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, cmd_ack_i = 1'b0;
    logic [1:0]  mem_kind_i = 2'd0;
    logic [15:0] tgt_mr0_i = '0, tgt_mr1_i = '0, tgt_mr2_i = '0, rd_data_i = '0;
    logic        cmd_stb_o, busy_o, done_o, err_o;
    logic [3:0]  cmd_op_o;
    logic [1:0]  cmd_mr_o;
    logic [15:0] cmd_data_o;

    int checks = 0, fails = 0, cyc = 0;
    logic [15:0] mdl [4];
    int lg_op [64], lg_mr [64], lg_data [64], lg_cyc [64], n_log = 0;
    int ex_op [64], ex_mr [64], ex_data [64], ex_cyc [64], n_exp = 0;
    int gap = 0, first_cyc = 0, exp_done = 0;
    bit exp_err = 0;
    bit ack_pend = 0;
    int ack_at = 0, pend_op = 0, pend_mr = 0, pend_data = 0;

    dram_reclk_seq i_dram_reclk_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_kind_i(mem_kind_i),
        .tgt_mr0_i(tgt_mr0_i), .tgt_mr1_i(tgt_mr1_i), .tgt_mr2_i(tgt_mr2_i),
        .cmd_stb_o(cmd_stb_o), .cmd_op_o(cmd_op_o), .cmd_mr_o(cmd_mr_o),
        .cmd_data_o(cmd_data_o), .cmd_ack_i(cmd_ack_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Responder: log strobes, acknowledge one cycle later, model MR storage.
    always @(negedge clk) begin
        cmd_ack_i = 1'b0;
        if (ack_pend && cyc == ack_at) begin
            cmd_ack_i = 1'b1;
            ack_pend = 0;
            if (pend_op == OPC_MRR) rd_data_i = mdl[pend_mr];
            if (pend_op == OPC_MRW) mdl[pend_mr] = 16'(pend_data);
        end
        if (cmd_stb_o) begin
            if (n_log < 64) begin
                lg_op[n_log] = int'(cmd_op_o); lg_mr[n_log] = int'(cmd_mr_o);
                lg_data[n_log] = int'(cmd_data_o); lg_cyc[n_log] = cyc;
                n_log = n_log + 1;
            end
            ack_pend = 1; ack_at = cyc + 1;
            pend_op = int'(cmd_op_o); pend_mr = int'(cmd_mr_o); pend_data = int'(cmd_data_o);
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int op, input int mr, input int data);
        ex_op[n_exp] = op; ex_mr[n_exp] = mr; ex_data[n_exp] = data;
        ex_cyc[n_exp] = (n_exp == 0) ? first_cyc : ex_cyc[n_exp-1] + 2 + gap;
        gap = 0;
        n_exp++;
    endtask

    // Expected command list built from R3 to R10.
    task automatic build_exp(input logic [1:0] k, input logic [15:0] t0, t1, t2, input int s);
        logic [15:0] m, c0, c1, c2;
        int lk;
        n_exp = 0; gap = 0; first_cyc = s + 1; exp_err = (k == 2'd3);
        if (k == 2'd3) begin exp_done = s + 1; return; end      // R3
        m  = (k == 2'd2) ? 16'h0040 : 16'h0001;                  // R5 mask
        lk = (k == 2'd0) ? 400 : (k == 2'd1) ? 2400 : 8000;      // R8 lock
        c0 = mdl[0]; c1 = mdl[1]; c2 = (k == 2'd1) ? mdl[2] : t2; // R4
        if (k == 2'd1) push(OPC_MRR, 2, 0);
        push(OPC_MRR, 1, 0); push(OPC_MRR, 0, 0);
        if ((c1 & m) == 0 && (t1 & m) != 0) begin                 // R5
            push(OPC_PRE, 0, 0); push(OPC_MRW, 1, int'(c1 | m)); gap += W_MRD;
        end
        push(OPC_PRE, 0, 0); push(OPC_REF, 0, 0); push(OPC_REF, 0, 0);  // R6
        push(OPC_AOFF, 0, 0); push(OPC_SON, 0, 0); gap += W_ZERO;
        push(OPC_CLK, 0, 0); gap += W_ZERO;
        push(OPC_PRE, 0, 0); push(OPC_SOFF, 0, 0); push(OPC_AON, 0, 0); gap += W_ZERO;
        if (c2 != t2) begin push(OPC_MRW, 2, int'(t2)); gap += W_MRD; end  // R7
        if (c1 != t1) begin push(OPC_MRW, 1, int'(t1)); gap += W_MRD; end
        if (c0 != t0) begin push(OPC_MRW, 0, int'(t0)); gap += W_MRD; end
        push(OPC_TIM, 0, 0);                                             // R8
        if ((t1 & m) == 0) begin
            push(OPC_MRW, 0, int'(t0 | 16'h0100)); gap += W_MRD;
            push(OPC_MRW, 0, int'(t0 & ~16'h0100)); gap += W_MRD + lk;
            if (k == 2'd2) push(OPC_PRE, 0, 0);                          // R9
        end
        exp_done = ex_cyc[n_exp-1] + 2 + gap;
    endtask

    // One full sequence: start, mid-run stray start, done-cycle start, log compare.
    task automatic run_seq(input string tag, input logic [1:0] k, input logic [15:0] t0, t1, t2);
        int s, nl;
        bit early = 0;
        @(negedge clk);
        s = cyc;
        build_exp(k, t0, t1, t2, s);
        n_log = 0;
        start_i = 1'b1; mem_kind_i = k; tgt_mr0_i = t0; tgt_mr1_i = t1; tgt_mr2_i = t2;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R11", {tag, " busy after start"}, int'(busy_o), 1);
        while (cyc < exp_done && cyc < s + 150000) begin
            if (done_o) early = 1;
            start_i    = (cyc == s + 10);            // R12 stray start mid-run
            mem_kind_i = (cyc == s + 10) ? 2'd3 : k;
            tgt_mr1_i  = (cyc == s + 10) ? 16'hFFFF : t1;
            @(negedge clk);
        end
        chk(!early, "R11", {tag, " no early done"}, int'(early), 0);
        chk(done_o == 1'b1, "R11", {tag, " done at predicted cycle"}, int'(done_o), 1);
        chk(err_o == exp_err, "R3", {tag, " error status"}, int'(err_o), int'(exp_err));
        start_i = 1'b1; mem_kind_i = 2'd0;           // R12 start in the done cycle
        @(negedge clk);
        start_i = 1'b0;
        nl = n_log;
        chk(done_o == 1'b0 && busy_o == 1'b0, "R12", {tag, " idle after done"},
            int'({done_o, busy_o}), 0);
        repeat (5) @(negedge clk);
        chk(busy_o == 1'b0 && n_log == nl, "R12", {tag, " done-cycle start ignored"},
            n_log, nl);
        chk(n_log == n_exp, tag, "command count", n_log, n_exp);
        for (int i = 0; i < n_exp && i < n_log; i++) begin
            chk(lg_op[i] == ex_op[i] && lg_mr[i] == ex_mr[i] && lg_data[i] == ex_data[i],
                tag, $sformatf("cmd %0d {op,mr,data}", i),
                (lg_op[i] << 20) | (lg_mr[i] << 16) | lg_data[i],
                (ex_op[i] << 20) | (ex_mr[i] << 16) | ex_data[i]);
            chk(lg_cyc[i] == ex_cyc[i], "R10", $sformatf("%s cmd %0d cycle", tag, i),
                lg_cyc[i], ex_cyc[i]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy_o, done_o, err_o, cmd_stb_o} == 4'b0, "R1", "outputs in reset",
            int'({busy_o, done_o, err_o, cmd_stb_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, done_o, err_o, cmd_stb_o} == 4'b0, "R1", "outputs after reset",
            int'({busy_o, done_o, err_o, cmd_stb_o}), 0);

        // R4 R5 R7: DDR3 with DLL switched off, every MR changes
        mdl[0] = 16'h0520; mdl[1] = 16'h0004; mdl[2] = 16'h0008; mdl[3] = 16'h0;
        run_seq("R5", 2'd1, 16'h0630, 16'h0005, 16'h0010);

        // R8 R7: DDR2, DLL stays on, only MR0 changes, MR2 not read
        mdl[0] = 16'h0432; mdl[1] = 16'h0000; mdl[2] = 16'h1234;
        run_seq("R8", 2'd0, 16'h0532, 16'h0000, 16'h7777);

        // R9 R5: GDDR3, bit 0 set but bit 6 clear means DLL on; trailing precharge
        mdl[0] = 16'h0101; mdl[1] = 16'h0001; mdl[2] = 16'h0000;
        run_seq("R9", 2'd2, 16'h0101, 16'h0001, 16'h0022);

        // R5 R9: GDDR3 switching DLL off on bit 6, no DLL reset, no trailing precharge
        mdl[0] = 16'h0101; mdl[1] = 16'h0001; mdl[2] = 16'h0000;
        run_seq("R6", 2'd2, 16'h0101, 16'h0041, 16'h0000);

        // R3: unsupported type code
        run_seq("R3", 2'd3, 16'h0000, 16'h0000, 16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule